// File: doc/BRIEF.md
# I2C Master Command and Receive Register Front-End

This block sits between a memory-mapped register port and the byte engine of an I2C master. Software writes command words into a small command queue; each word says whether a START precedes the byte, whether a STOP follows it, and which byte goes out (its lowest bit doubles as the read/write flag of an address byte). The block offers the head of that queue to the byte engine over a valid/ready handshake. Bytes received by the engine land in a receive queue that software drains by reading a data register. A read of the bus is therefore paced by the command queue: software pushes one command for every byte it wants back.

Error events from the engine (NACK seen, arbitration lost) and a receive overflow set sticky status bits that software clears by writing ones. Two further status bits are not latched: they follow the fill levels of the queues against thresholds held in the control register. One interrupt line is the OR of all status bits that software has enabled. Clearing the enable bit empties both queues and holds the byte engine in its idle state.

Top module: `i2cfe_regfront`

## Requirements
- R1: After reset the control, interrupt-enable and sticky bits are zero, both fill levels read 0, the status register at 0x14 reads 0, the interrupt status at 0x10 reads 0x01 (transmit-ready only), `irq` and `cmd_valid` are low.
- R2: A write to 0x00 while enabled and the command queue not full stores the 10-bit word (bit 9 START, bit 8 STOP, bits 7:0 byte, bit 0 read flag when the byte is an address); a write while full or while disabled is dropped. The command fill level reads at 0x18 and never exceeds DEPTH.
- R3: Commands leave in write order on `cmd_word` with `cmd_valid` high; an offered word stays stable until `cmd_ready`, and each accepted handshake removes exactly one word.
- R4: Each `rx_valid` cycle while enabled stores `rx_byte`; a read of 0x04 returns the oldest byte in bits 7:0 and removes it, and returns 0 when the queue is empty. The receive fill level reads at 0x1C.
- R5: The control register at 0x08 holds enable in bit 0, fast bus speed in bit 1 (driven on `bus_fast`), the command threshold in bits 3:2 and the receive threshold in bits 5:4; it reads back these six bits with all upper bits zero.
- R6: Interrupt-status bit 1 (receive ready) reads 1 exactly when the receive level exceeds the receive threshold; bit 0 (transmit ready) reads 1 exactly when the command level is at or below the command threshold. Writes to 0x10 do not change either bit.
- R7: A pulse on `evt_nack` sets status bit 2 and a pulse on `evt_arb` sets bit 3; each stays set until a write of 1 to that bit at 0x10, a written 0 leaves it, and an event in the same cycle as the clearing write leaves the bit set.
- R8: A received byte arriving while the receive queue holds DEPTH bytes is dropped, sets status bit 4 (sticky, cleared like R7), and leaves the stored bytes unchanged.
- R9: `irq` is high exactly when some bit of the interrupt status at 0x10 is high together with the same bit of the enable register at 0x0C (five bits, same layout).
- R10: Bit 0 of 0x14 reads 1 when `eng_busy` is high or the command queue is not empty, else 0.
- R11: While enable is 0 both queues are empty, `eng_flush` is high, `cmd_valid` is low, and received bytes are ignored without setting the overflow bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid the cycle after `bus_rd` |
| irq | output | 1 | Interrupt request |
| cmd_valid | output | 1 | A command word is offered to the engine |
| cmd_ready | input | 1 | Engine takes the offered word |
| cmd_word | output | 10 | START, STOP and byte of the offered command |
| bus_fast | output | 1 | Fast bus speed selected |
| eng_flush | output | 1 | Holds the byte engine idle while disabled |
| eng_busy | input | 1 | Byte engine is working on a command |
| rx_valid | input | 1 | Engine delivers a received byte |
| rx_byte | input | 8 | Received byte |
| evt_nack | input | 1 | Engine saw a NACK |
| evt_arb | input | 1 | Engine lost arbitration |

## Verification
Every cycle, assertions watch that an offered command stays still until taken, that event pulses always land in the sticky bits and survive until a clearing write, that an arriving byte on a full receive queue raises overflow, that disabling empties both queues, and that the fill counters stay in range. The threshold comparisons, the ordering of words through both queues, the dropped pushes and the read-back of every register need the bench's sweeps over threshold and fill level, since those are relations between what software writes and what it later reads.

// File: rtl/i2cfe_pkg.sv
package i2cfe_pkg;
   // register byte offsets
   localparam logic [7:0] OFS_CMD   = 8'h00;
   localparam logic [7:0] OFS_RXD   = 8'h04;
   localparam logic [7:0] OFS_CTRL  = 8'h08;
   localparam logic [7:0] OFS_IEN   = 8'h0C;
   localparam logic [7:0] OFS_ISR   = 8'h10;
   localparam logic [7:0] OFS_STAT  = 8'h14;
   localparam logic [7:0] OFS_CLVL  = 8'h18;
   localparam logic [7:0] OFS_RLVL  = 8'h1C;

   localparam int CMD_W   = 10;
   localparam int BYTE_W  = 8;
   localparam int CTRL_W  = 6;
   localparam int THR_W   = 2;
   localparam int IRQ_N   = 5;
   localparam int STICKY_N = 3;

   // status bit positions, shared by enable and status registers
   typedef enum int {
      IB_TXRDY = 0,
      IB_RXRDY = 1,
      IB_NACK  = 2,
      IB_ARB   = 3,
      IB_OVF   = 4
   } irq_bit_e;

   typedef struct packed {
      logic [THR_W-1:0] rx_thr;
      logic [THR_W-1:0] cmd_thr;
      logic             fast;
      logic             en;
   } ctrl_t;
endpackage

// File: rtl/i2cfe_fifo.sv
module i2cfe_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 4,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int LVL_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             push,
   input  logic [W-1:0]     wdata,
   input  logic             pop,
   output logic [W-1:0]     rdata,
   output logic             full,
   output logic             empty,
   output logic [LVL_W-1:0] level
);
   initial begin : p_param_chk
      assert (DEPTH >= 2 && (DEPTH & (DEPTH - 1)) == 0)
         else $fatal(1, "i2cfe_fifo: DEPTH must be a power of two >= 2");
   end

   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr;
   logic [LVL_W-1:0] cnt;
   logic             do_push, do_pop;

   assign full    = (cnt == LVL_W'(DEPTH));
   assign empty   = (cnt == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign rdata   = empty ? '0 : mem[rd_ptr];
   assign level   = cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int e = 0; e < DEPTH; e++) mem[e] <= '0;
      end else if (do_push && !flush) begin
         mem[wr_ptr] <= wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + 1'b1;
         if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
         unique case ({do_push, do_pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   AST_FIFO_LEVEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      32'(cnt) <= DEPTH);                                           // R2
   AST_FIFO_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      full && !pop && !flush |=> full);                             // R8
endmodule

// File: rtl/i2cfe_evtstat.sv
module i2cfe_evtstat #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic         clr_we,
   input  logic [N-1:0] clr_mask,
   output logic [N-1:0] flags
);
   initial begin : p_param_chk
      assert (N >= 1) else $fatal(1, "i2cfe_evtstat: N must be >= 1");
   end

   for (genvar b = 0; b < N; b++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!rst_n)                      flags[b] <= 1'b0;
         else if (set[b])                 flags[b] <= 1'b1;
         else if (clr_we && clr_mask[b])  flags[b] <= 1'b0;
      end

      AST_EVT_SET: assert property (@(posedge clk) disable iff (!rst_n)
         set[b] |=> flags[b]);                                      // R7
      AST_EVT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         flags[b] && !(clr_we && clr_mask[b]) |=> flags[b]);        // R7
   end
endmodule

// File: rtl/i2cfe_regfront.sv
module i2cfe_regfront
   import i2cfe_pkg::*;
#(
   parameter int DEPTH  = 4,
   parameter int DATA_W = 32,
   parameter int ADDR_W = 5,
   localparam int LVL_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq,
   output logic              cmd_valid,
   input  logic              cmd_ready,
   output logic [CMD_W-1:0]  cmd_word,
   output logic              bus_fast,
   output logic              eng_flush,
   input  logic              eng_busy,
   input  logic              rx_valid,
   input  logic [BYTE_W-1:0] rx_byte,
   input  logic              evt_nack,
   input  logic              evt_arb
);
   initial begin : p_param_chk
      assert (ADDR_W >= 5 && ADDR_W <= 8)
         else $fatal(1, "i2cfe_regfront: ADDR_W must be 5..8");
      assert (DATA_W >= 16)
         else $fatal(1, "i2cfe_regfront: DATA_W must be >= 16");
      assert (DEPTH >= 2 && DEPTH <= 4)
         else $fatal(1, "i2cfe_regfront: DEPTH must fit the 2-bit thresholds");
   end

   // ---------------- address decode ----------------
   logic sel_cmd, sel_rxd, sel_ctrl, sel_ien, sel_isr, sel_stat, sel_clvl, sel_rlvl;
   assign sel_cmd  = (bus_addr == OFS_CMD[ADDR_W-1:0]);
   assign sel_rxd  = (bus_addr == OFS_RXD[ADDR_W-1:0]);
   assign sel_ctrl = (bus_addr == OFS_CTRL[ADDR_W-1:0]);
   assign sel_ien  = (bus_addr == OFS_IEN[ADDR_W-1:0]);
   assign sel_isr  = (bus_addr == OFS_ISR[ADDR_W-1:0]);
   assign sel_stat = (bus_addr == OFS_STAT[ADDR_W-1:0]);
   assign sel_clvl = (bus_addr == OFS_CLVL[ADDR_W-1:0]);
   assign sel_rlvl = (bus_addr == OFS_RLVL[ADDR_W-1:0]);

   // ---------------- control and enable registers ----------------
   ctrl_t            ctrl_q;
   logic [IRQ_N-1:0] ien_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         ien_q  <= '0;
      end else if (bus_wr) begin
         if (sel_ctrl) ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
         if (sel_ien)  ien_q  <= bus_wdata[IRQ_N-1:0];
      end
   end

   assign bus_fast  = ctrl_q.fast;
   assign eng_flush = !ctrl_q.en;

   // ---------------- command queue ----------------
   logic             cq_full, cq_empty, cq_push, cq_pop;
   logic [LVL_W-1:0] cq_lvl;
   logic [CMD_W-1:0] cq_head;

   assign cq_push   = bus_wr && sel_cmd && ctrl_q.en;
   assign cmd_valid = ctrl_q.en && !cq_empty;
   assign cq_pop    = cmd_valid && cmd_ready;
   assign cmd_word  = cq_head;

   i2cfe_fifo #(.W(CMD_W), .DEPTH(DEPTH)) u_cmdq (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (!ctrl_q.en),
      .push  (cq_push),
      .wdata (bus_wdata[CMD_W-1:0]),
      .pop   (cq_pop),
      .rdata (cq_head),
      .full  (cq_full),
      .empty (cq_empty),
      .level (cq_lvl)
   );

   // ---------------- receive queue ----------------
   logic              rq_full, rq_empty, rq_push, rq_pop, rq_ovf;
   logic [LVL_W-1:0]  rq_lvl;
   logic [BYTE_W-1:0] rq_head;

   assign rq_push = rx_valid && ctrl_q.en;
   assign rq_ovf  = rq_push && rq_full;
   assign rq_pop  = bus_rd && sel_rxd;

   i2cfe_fifo #(.W(BYTE_W), .DEPTH(DEPTH)) u_rxq (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (!ctrl_q.en),
      .push  (rq_push),
      .wdata (rx_byte),
      .pop   (rq_pop),
      .rdata (rq_head),
      .full  (rq_full),
      .empty (rq_empty),
      .level (rq_lvl)
   );

   // ---------------- interrupt status ----------------
   logic [STICKY_N-1:0] sticky;
   logic                tx_rdy, rx_rdy;
   logic [IRQ_N-1:0]    isr_view;

   i2cfe_evtstat #(.N(STICKY_N)) u_evt (
      .clk      (clk),
      .rst_n    (rst_n),
      .set      ({rq_ovf, evt_arb, evt_nack}),
      .clr_we   (bus_wr && sel_isr),
      .clr_mask (bus_wdata[IB_OVF:IB_NACK]),
      .flags    (sticky)
   );

   assign tx_rdy   = 32'(cq_lvl) <= 32'(ctrl_q.cmd_thr);
   assign rx_rdy   = 32'(rq_lvl) >  32'(ctrl_q.rx_thr);
   assign isr_view = {sticky, rx_rdy, tx_rdy};
   assign irq      = |(isr_view & ien_q);

   // ---------------- read path ----------------
   logic [DATA_W-1:0] rd_mux;
   logic              busy;

   assign busy = eng_busy || !cq_empty;

   always_comb begin
      rd_mux = '0;
      if (sel_rxd)  rd_mux = DATA_W'(rq_head);
      if (sel_ctrl) rd_mux = DATA_W'(ctrl_q);
      if (sel_ien)  rd_mux = DATA_W'(ien_q);
      if (sel_isr)  rd_mux = DATA_W'(isr_view);
      if (sel_stat) rd_mux = DATA_W'(busy);
      if (sel_clvl) rd_mux = DATA_W'(cq_lvl);
      if (sel_rlvl) rd_mux = DATA_W'(rq_lvl);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= rd_mux;
   end

   logic unused_wdata;
   assign unused_wdata = ^{bus_wdata[DATA_W-1:CMD_W], sel_cmd && bus_rd};

   // ---------------- assertions ----------------
   AST_CMD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && !cmd_ready |=> !ctrl_q.en || (cmd_valid && $stable(cmd_word))); // R3
   AST_RX_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid && ctrl_q.en && rq_full |=> sticky[2]);              // R8
   AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_q.en |=> cq_lvl == '0 && rq_lvl == '0);                 // R11
   AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      ien_q == '0 |-> !irq);                                        // R9
   AST_NO_CMD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      eng_flush |-> !cmd_valid);                                    // R11
endmodule

// File: tb/i2cfe_regfront_tb.sv
module i2cfe_regfront_tb_top;
   localparam int DEPTH = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq, cmd_valid, bus_fast, eng_flush;
   logic        cmd_ready = 1'b0, eng_busy = 1'b0, rx_valid = 1'b0;
   logic [9:0]  cmd_word;
   logic [7:0]  rx_byte = '0;
   logic        evt_nack = 1'b0, evt_arb = 1'b0;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;  // 125 MHz

   i2cfe_regfront #(.DEPTH(DEPTH)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq(irq), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_word(cmd_word), .bus_fast(bus_fast), .eng_flush(eng_flush),
      .eng_busy(eng_busy), .rx_valid(rx_valid), .rx_byte(rx_byte),
      .evt_nack(evt_nack), .evt_arb(evt_arb)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(logic [4:0] a, logic [31:0] d);
      @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk); bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(logic [4:0] a, output logic [31:0] v);
      @(negedge clk); bus_rd = 1'b1; bus_addr = a;
      @(negedge clk); bus_rd = 1'b0; v = bus_rdata;
   endtask

   task automatic rx_in(logic [7:0] b);
      @(negedge clk); rx_valid = 1'b1; rx_byte = b;
      @(negedge clk); rx_valid = 1'b0;
   endtask

   function automatic logic [9:0] cmd_exp(int i);
      return 10'((i == 0 ? 10'h200 : 10'h0) | (i == 3 ? 10'h100 : 10'h0) | 10'((i * 37 + 5) & 8'hFF));
   endfunction

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : stim
      logic [31:0] v;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 irq", 32'(irq), 0);
      chk("R1 cmd_valid", 32'(cmd_valid), 0);
      rd(5'h10, v); chk("R1 isr", v, 32'h1);
      rd(5'h08, v); chk("R1 ctrl", v, 0);
      rd(5'h0C, v); chk("R1 ien", v, 0);
      rd(5'h14, v); chk("R1 status", v, 0);
      rd(5'h18, v); chk("R1 cmd level", v, 0);
      rd(5'h1C, v); chk("R1 rx level", v, 0);

      // R5 control read-back and speed pin
      wr(5'h08, 32'hFFFF_FFFF);
      rd(5'h08, v); chk("R5 ctrl readback", v, 32'h3F);
      chk("R5 bus_fast", 32'(bus_fast), 1);
      wr(5'h08, 32'h0);
      chk("R5 bus_fast off", 32'(bus_fast), 0);

      // R2 push while disabled is dropped
      wr(5'h00, 32'h2A5);
      rd(5'h18, v); chk("R2 push while disabled", v, 0);

      // R2/R3 ordering, overflow drop, stability
      wr(5'h08, 32'h1);
      for (int i = 0; i < 5; i++) wr(5'h00, 32'(cmd_exp(i)));
      rd(5'h18, v); chk("R2 cmd level at full", v, DEPTH);
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk("R3 held valid", 32'(cmd_valid), 1);
         chk("R3 held word", 32'(cmd_word), 32'(cmd_exp(0)));
      end
      for (int i = 0; i < DEPTH; i++) begin
         @(negedge clk);
         chk("R3 valid", 32'(cmd_valid), 1);
         chk("R3 word order", 32'(cmd_word), 32'(cmd_exp(i)));
         cmd_ready = 1'b1;
         @(negedge clk); cmd_ready = 1'b0;
      end
      chk("R3 drained", 32'(cmd_valid), 0);

      // R6 transmit-ready sweep over threshold and level
      for (int t = 0; t < 4; t++) begin
         for (int n = 0; n <= DEPTH + 1; n++) begin
            int lvl;
            lvl = (n > DEPTH) ? DEPTH : n;
            wr(5'h08, 32'h0);
            wr(5'h08, 32'(1 | (t << 2)));
            for (int p = 0; p < n; p++) wr(5'h00, 32'(p));
            rd(5'h18, v); chk("R2 cmd level sweep", v, 32'(lvl));
            rd(5'h10, v); chk("R6 tx ready sweep", 32'(v[0]), 32'(lvl <= t));
         end
      end

      // R6/R8 receive-ready and overflow sweep
      for (int t = 0; t < 4; t++) begin
         for (int n = 0; n <= DEPTH + 1; n++) begin
            int lvl;
            lvl = (n > DEPTH) ? DEPTH : n;
            wr(5'h08, 32'h0);
            wr(5'h10, 32'h1F);
            wr(5'h08, 32'(1 | (t << 4)));
            for (int p = 0; p < n; p++) rx_in(8'(p + 8'h40));
            rd(5'h1C, v); chk("R4 rx level sweep", v, 32'(lvl));
            rd(5'h10, v);
            chk("R6 rx ready sweep", 32'(v[1]), 32'(lvl > t));
            chk("R8 overflow sweep", 32'(v[4]), 32'(n > DEPTH));
         end
      end

      // R8 contents unchanged after overflow, R4 order and empty read
      for (int i = 0; i < DEPTH; i++) begin
         rd(5'h04, v); chk("R4 R8 rx byte order", v, 32'(8'h40 + i));
      end
      rd(5'h04, v); chk("R4 empty read", v, 0);
      wr(5'h10, 32'h10);
      rd(5'h10, v); chk("R8 overflow cleared", 32'(v[4]), 0);

      // R6 writes do not touch ready bits
      wr(5'h08, 32'h1);
      wr(5'h10, 32'h03);
      rd(5'h10, v); chk("R6 tx ready ignores write", 32'(v[0]), 1);

      // R7 sticky events
      @(negedge clk); evt_nack = 1'b1;
      @(negedge clk); evt_nack = 1'b0;
      wr(5'h10, 32'h0);
      rd(5'h10, v); chk("R7 nack sticky", 32'(v[2]), 1);
      wr(5'h10, 32'h04);
      rd(5'h10, v); chk("R7 nack cleared", 32'(v[2]), 0);
      @(negedge clk); evt_arb = 1'b1;
      @(negedge clk); evt_arb = 1'b0;
      rd(5'h10, v); chk("R7 arb sticky", 32'(v[3]), 1);
      @(negedge clk); evt_arb = 1'b1; bus_wr = 1'b1; bus_addr = 5'h10; bus_wdata = 32'h08;
      @(negedge clk); evt_arb = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
      rd(5'h10, v); chk("R7 set beats clear", 32'(v[3]), 1);
      wr(5'h10, 32'h08);
      rd(5'h10, v); chk("R7 arb cleared", 32'(v[3]), 0);

      // R9 interrupt line
      wr(5'h0C, 32'h04);
      chk("R9 irq no event", 32'(irq), 0);
      @(negedge clk); evt_nack = 1'b1;
      @(negedge clk); evt_nack = 1'b0;
      chk("R9 irq nack", 32'(irq), 1);
      wr(5'h0C, 32'h0);
      chk("R9 irq masked", 32'(irq), 0);
      wr(5'h0C, 32'h01);
      chk("R9 irq tx ready", 32'(irq), 1);
      wr(5'h0C, 32'h0);
      wr(5'h10, 32'h1F);

      // R10 busy
      eng_busy = 1'b1;
      rd(5'h14, v); chk("R10 engine busy", v, 1);
      eng_busy = 1'b0;
      wr(5'h00, 32'h055);
      rd(5'h14, v); chk("R10 queue busy", v, 1);
      @(negedge clk); cmd_ready = 1'b1;
      @(negedge clk); cmd_ready = 1'b0;
      rd(5'h14, v); chk("R10 idle", v, 0);

      // R11 disable flushes and ignores received bytes
      wr(5'h00, 32'h011);
      wr(5'h00, 32'h022);
      rx_in(8'h99);
      wr(5'h08, 32'h0);
      @(negedge clk);
      chk("R11 eng_flush", 32'(eng_flush), 1);
      chk("R11 cmd_valid off", 32'(cmd_valid), 0);
      for (int k = 0; k < DEPTH + 1; k++) rx_in(8'(k));
      wr(5'h08, 32'h1);
      chk("R11 eng_flush released", 32'(eng_flush), 0);
      rd(5'h18, v); chk("R11 cmd flushed", v, 0);
      rd(5'h1C, v); chk("R11 rx flushed", v, 0);
      rd(5'h10, v); chk("R11 no overflow", 32'(v[4]), 0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule